// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives a slower clock from a master clock by dividing it by a programmable integer. A level-sensitive enable starts and stops the output without producing runt pulses. When the enable drops, a low output stops at once. A high output first finishes its full high phase and then stays low. While the output is stopped, the divide counter is held at zero. Each restart therefore begins with the same phase relative to the enable edge.

The enable may come from any clock domain and is first passed through a two-stage synchronizer on the master clock. The divide value is a plain control input. The block samples it only while stopped or at the end of a full output period, so it may change at any time. The output comes straight from a flop. Because of this the smallest usable divisor is 2, and a request for 1 is served as 2.

Top module: `gated_divider`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low. After reset, `clk_out` stays low until the enable is seen high.
- R2: The effective divisor is Ne = `div_m1` + 1, except that `div_m1` = 0 gives Ne = 2. With the enable held high, `clk_out` repeats a period of exactly Ne master cycles: high for H = ceil(Ne/2) cycles, then low for L = floor(Ne/2) cycles.
- R3: For odd Ne the high phase is one master cycle longer than the low phase. For even Ne the two phases are equal.
- R4: `div_m1` covers the full range 0..255, including Ne = 256 (H = L = 128) and the value 0 served as Ne = 2.
- R5: If the synchronized enable is low while `clk_out` is low, `clk_out` stays low from that cycle on, including through the point where a new period would have begun.
- R6: If the synchronized enable goes low while `clk_out` is high, the high phase still lasts its full H cycles. `clk_out` then falls and stays low.
- R7: While stopped, the counter is held at zero. `clk_out` rises on the third rising master edge after `en_in` rises, counting the two synchronizer stages. It then starts a fresh period with its full high phase, so the phase is the same on every restart.
- R8: A change of `div_m1` takes effect only at the start of a period: on a restart, or after a full low phase. The period in progress keeps its old H and L.
- R9: Every high pulse of `clk_out` lasts exactly H cycles of the divisor latched at its start, under any pattern of enable toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_in | input | 1 | Output enable, asynchronous to `clk` |
| div_m1 | input | CNT_W (8) | Divisor minus one |
| clk_out | output | 1 | Divided, gated clock output |

## Verification
The output is a registered function of the synchronized enable. An `en_in` edge therefore shows up at `clk_out` after three rising master edges, and a `div_m1` change shows up only at the next period boundary. The bench drives inputs on falling edges. A cycle model in the bench steps through the two synchronizer stages and the output register on each rising edge, and `clk_out` is compared with that model on the next falling edge. Separate checks measure the width of every high pulse and count the exact edges from an enable rise to the first output rise.

// File: rtl/gdiv_pkg.sv
package gdiv_pkg;
  // Effective divisor from the divisor-minus-one code; code 0 is served as 2.
  function automatic logic [15:0] eff_div(input logic [15:0] m1);
    return (m1 == 16'd0) ? 16'd2 : m1 + 16'd1;
  endfunction

  // Cycles the output stays high for a given divisor (ceiling of half).
  function automatic logic [15:0] high_len(input logic [15:0] n);
    return (n + 16'd1) >> 1;
  endfunction
endpackage

// File: rtl/gdiv_sync.sv
module gdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/gdiv_core.sv
module gdiv_core
  import gdiv_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_s,
  input  logic [CNT_W-1:0] div_m1,
  output logic             out_q
);
  localparam int NW = CNT_W + 1;

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [NW-1:0]    n_q, n_in, h_q, cnt_nx;
  logic             last, next_hi, stop;

  logic [15:0] e16, h16;
  assign e16    = eff_div(16'(div_m1));
  assign n_in   = e16[NW-1:0];
  assign h16    = high_len(16'(n_q));
  assign h_q    = h16[NW-1:0];
  assign cnt_nx = {1'b0, cnt} + NW'(1);
  assign last   = (cnt_nx == n_q);
  assign next_hi = last ? 1'b1 : (cnt_nx < h_q);
  // Park when disabled, but only where the output is (or is about to be) low.
  assign stop   = !en_s && (!out_q || !next_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      out_q <= 1'b0;
      n_q   <= NW'(2);
    end else if (!run) begin
      cnt   <= '0;
      n_q   <= n_in;
      out_q <= en_s;
      run   <= en_s;
    end else if (stop) begin
      run   <= 1'b0;
      cnt   <= '0;
      out_q <= 1'b0;
    end else begin
      out_q <= next_hi;
      if (last) begin
        cnt <= '0;
        n_q <= n_in;
      end else begin
        cnt <= cnt_nx[CNT_W-1:0];
      end
    end
  end

  // Width of the current high phase, for the pulse-width assertion.
  logic [NW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_run <= '0;
    else if (!out_q) hi_run <= '0;
    else             hi_run <= hi_run + NW'(1);
  end

  assert_full_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q) |-> (hi_run == h_q));
  assert_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!out_q && cnt == '0));
  assert_restart_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> out_q);
  assert_div_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && cnt != '0) |-> $stable(n_q));
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({1'b0, cnt} < n_q));
  assert_low_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !en_s && !out_q) |=> !out_q);
endmodule

// File: rtl/gated_divider.sv
module gated_divider #(
  parameter int CNT_W     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_in,
  input  logic [CNT_W-1:0] div_m1,
  output logic             clk_out
);
  logic en_s;

  gdiv_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(en_in), .q(en_s)
  );

  gdiv_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .div_m1(div_m1), .out_q(clk_out)
  );
endmodule

// File: tb/gated_divider_tb.sv
module gated_divider_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_in = 1'b0;
  logic [7:0] div_m1 = 8'd3;
  logic       clk_out;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  gated_divider u_dut (.clk(clk), .rst_n(rst_n), .en_in(en_in), .div_m1(div_m1), .clk_out(clk_out));

  function automatic int n_of(input int m1);
    return (m1 == 0) ? 2 : m1 + 1;
  endfunction
  function automatic int hi_of(input int n);
    return (n + 1) / 2;
  endfunction
  function automatic int lo_of(input int n);
    return n / 2;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model built from the requirements: phases with remaining-cycle counts.
  int m_s1 = 0, m_s2 = 0, m_on = 0, m_high = 0, m_rem = 0, m_n = 2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_on = 0; m_high = 0; m_rem = 0; m_n = 2;
    end else begin
      if (!m_on) begin
        m_n = n_of(div_m1);
        if (m_s2 != 0) begin
          m_on = 1; m_high = 1; m_rem = hi_of(m_n) - 1;
        end
      end else begin
        int old_high;
        old_high = m_high;
        if (m_rem > 0) m_rem--;
        else if (m_high != 0) begin
          m_high = 0; m_rem = lo_of(m_n) - 1;
        end else begin
          m_n = n_of(div_m1); m_high = 1; m_rem = hi_of(m_n) - 1;
        end
        if (m_s2 == 0 && (old_high == 0 || m_high == 0)) begin
          m_on = 0; m_high = 0;
        end
      end
      m_s2 = m_s1;
      m_s1 = en_in;
    end
  end

  // Per-cycle comparison and pulse-width monitor, away from the active edge.
  int hi_cnt = 0, hi_exp = 0, prev_out = 0, started = 0;
  always @(negedge clk) begin
    if (rst_n && started != 0) begin
      check(cur_req, clk_out, m_high);
      if (clk_out) begin
        if (!prev_out) begin hi_cnt = 0; hi_exp = hi_of(m_n); end
        hi_cnt++;
      end else if (prev_out) begin
        check("R9 pulse width", hi_cnt, hi_exp);
      end
      prev_out = clk_out;
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    fails++;
    $display("FAIL watchdog: actual %0d expected <150000 cycles", wd);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic run_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 in reset", clk_out, 0);
    rst_n = 1'b1;
    run_cycles(6);
    check("R1 idle after reset", clk_out, 0);
    started = 1;

    // R7: exact restart latency
    cur_req = "R7";
    div_m1 = 8'd7;
    @(negedge clk) en_in = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R7 not yet high after two edges", clk_out, 0);
    @(posedge clk);
    #1 check("R7 high on third edge", clk_out, 1);

    // R2: even divisor steady run
    cur_req = "R2"; run_cycles(40);
    // R3: odd divisor
    cur_req = "R3"; div_m1 = 8'd4; run_cycles(40);
    // R4: code 0 served as 2, and maximum 256
    cur_req = "R4"; div_m1 = 8'd0; run_cycles(20);
    div_m1 = 8'd255; run_cycles(600);

    // R6: disable right at a rising output
    cur_req = "R6"; div_m1 = 8'd9; run_cycles(30);
    while (clk_out !== 1'b1) @(negedge clk);
    en_in = 1'b0;
    run_cycles(4);
    check("R6 still high mid-pulse", clk_out, 1);
    run_cycles(30);
    check("R6 parked low", clk_out, 0);

    // R5: disable during a low phase
    cur_req = "R5"; div_m1 = 8'd5; en_in = 1'b1; run_cycles(20);
    while (clk_out !== 1'b0) @(negedge clk);
    en_in = 1'b0;
    begin
      int seen_high;
      seen_high = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (i >= 3 && clk_out) seen_high = 1;
      end
      check("R5 stays low", seen_high, 0);
    end

    // R8: divisor change mid-period
    cur_req = "R8"; div_m1 = 8'd11; en_in = 1'b1; run_cycles(30);
    while (clk_out !== 1'b1) @(negedge clk);
    run_cycles(2);
    div_m1 = 8'd1;
    run_cycles(40);

    // R9: random enable toggling and divisor changes
    cur_req = "R9";
    for (int seg = 0; seg < 400; seg++) begin
      if ($urandom_range(0, 3) == 0) div_m1 = 8'($urandom_range(0, 255));
      else div_m1 = 8'($urandom_range(0, 12));
      en_in = 1'($urandom_range(0, 1));
      run_cycles($urandom_range(1, 60));
    end
    en_in = 1'b0;
    run_cycles(300);
    check("R9 final parked", clk_out, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule